// File: doc/BRIEF.md
# Phase-Shifted Bridge PWM Modulator

This block turns a signed digital demand into the two gate-drive levels of one H-bridge. A single up/down counter forms a triangle carrier. Half-bridge A compares the demand against the carrier directly. Half-bridge B compares it against the carrier mirrored about the ramp, which is the same triangle shifted by half a period. With zero demand the two legs switch together at 50% duty, so the load sees no differential voltage. A positive demand widens A and narrows B by the same amount, which drives current from A to B. A negative demand does the reverse.

The demand is a two's-complement offset from mid-scale and is clamped to the carrier range, so the duty saturates cleanly. The carrier ramp length can be changed at run time through an input. A strobe marks every peak and every valley of the carrier. Dead-time insertion, current sensing and the power stage are outside this block.

Top module: `phase_shift_pwm`

## Requirements
- R1: While `rst_n` is low, `drive_a` and `drive_b` are both 0.
- R2: With `half_period` = P (P even, P >= 2), the carrier period is 2P cycles. `peak_stb` is high on exactly two cycles per period, and consecutive strobes are P cycles apart.
- R3: With the level defined as L = clamp(P/2 + `demand`, 0, P) and `en` high, `drive_a` is high on exactly 2L cycles of every 2P-cycle window.
- R4: Under the same conditions, `drive_b` is high on exactly 2(P - L) cycles of every 2P-cycle window, so its duty moves opposite to A by the same amount.
- R5: With `demand` = 0 and `en` high, `drive_a` equals `drive_b` on every cycle. Each is high for P of every 2P cycles.
- R6: For `demand` >= P/2, `drive_a` is constantly 1 and `drive_b` constantly 0. For `demand` <= -P/2 the reverse holds. Demands beyond these values give the same outputs as the limit.
- R7: One cycle after `en` goes low, both drive outputs are 0 and stay 0 while `en` is low. The carrier keeps running, so `peak_stb` still pulses twice per 2P cycles.
- R8: For 0 < L < P with L != P/2, the differential signal `drive_a` XOR `drive_b` has exactly two rising edges per carrier period. This doubles the chopping frequency relative to the carrier.
- R9: The drive outputs are registered. A change of `en` or `demand` appears at the outputs one clock later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| en | input | 1 | Bridge enable; low forces both drives low |
| half_period | input | CW | Carrier ramp length P in cycles (even, at least 2) |
| demand | input | CW+1 | Signed offset of the demand from mid-scale |
| drive_a | output | 1 | Drive level for half-bridge A |
| drive_b | output | 1 | Drive level for half-bridge B |
| peak_stb | output | 1 | High on carrier peak and valley turn cycles |

## Verification
The bench counts high cycles over whole carrier windows at zero, positive and negative demand and at two ramp lengths. A comparator that is off by one, or a mirror taken about the wrong point, shows up as an odd count or as A and B drifting out of phase at mid-scale. Demands at and beyond the clamp limits are applied to catch an unclamped sum that wraps around and gives a wrong duty instead of a saturated one. The bench also checks that disabling forces both legs low without stopping the strobe. It counts differential edges, so a carrier that skips its dwell at the turning points, or a leg that uses the same reference as the other, gives the wrong chop count.

// File: rtl/pwm_mod_pkg.sv
package pwm_mod_pkg;
  // Ramp direction of the triangle carrier.
  typedef enum logic {RAMP_UP = 1'b0, RAMP_DOWN = 1'b1} ramp_dir_e;
endpackage

// File: rtl/tri_carrier.sv
module tri_carrier
  import pwm_mod_pkg::*;
#(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] half_period,
  output logic [CW-1:0] cnt,
  output logic          turn
);
  ramp_dir_e     dir;
  logic [CW-1:0] top_val;
  logic          at_top;
  logic          at_bottom;

  assign top_val   = half_period - CW'(1);
  assign at_top    = (cnt >= top_val);
  assign at_bottom = (cnt == '0);

  // Turn cycles dwell on the extreme value, so every value appears twice.
  always_comb begin
    turn = 1'b0;
    if (dir == RAMP_UP && at_top)      turn = 1'b1;
    if (dir == RAMP_DOWN && at_bottom) turn = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0;
      dir <= RAMP_UP;
    end else if (turn) begin
      dir <= (dir == RAMP_UP) ? RAMP_DOWN : RAMP_UP;
    end else if (dir == RAMP_UP) begin
      cnt <= cnt + CW'(1);
    end else begin
      cnt <= cnt - CW'(1);
    end
  end

  // R2: carrier moves by at most one step per cycle
  p_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == $past(cnt)) || (cnt == $past(cnt) + CW'(1)) || (cnt == $past(cnt) - CW'(1)));

  // R2: with a ramp of two or more, turn cycles never come back to back
  p_strobe_gap_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (turn && half_period > CW'(1) && at_top) |=> !turn);
endmodule

// File: rtl/bridge_leg.sv
module bridge_leg #(
  parameter int CW     = 8,
  parameter bit MIRROR = 1'b0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic [CW-1:0] cnt,
  input  logic [CW-1:0] half_period,
  input  logic [CW:0]   lvl,
  output logic          drv
);
  localparam int XW = CW + 2;
  logic hit;

  generate
    if (MIRROR) begin : g_mirror
      // Mirrored carrier (P-1-cnt) >= lvl, rewritten without subtraction.
      logic [XW-1:0] sum;
      assign sum = XW'(cnt) + XW'(lvl);
      assign hit = (sum < XW'(half_period));
    end else begin : g_direct
      assign hit = (XW'(cnt) < XW'(lvl));
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) drv <= 1'b0;
    else        drv <= en & hit;
  end

  // R7: a disabled cycle yields a low drive on the next cycle
  p_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !drv);
endmodule

// File: rtl/phase_shift_pwm.sv
module phase_shift_pwm #(
  parameter int CW = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                en,
  input  logic [CW-1:0]       half_period,
  input  logic signed [CW:0]  demand,
  output logic                drive_a,
  output logic                drive_b,
  output logic                peak_stb
);
  localparam int SW = CW + 2;

  // Compare level: mid-scale plus signed demand, clamped to [0, P].
  function automatic logic [CW:0] level_of(input logic [CW-1:0] p,
                                           input logic signed [CW:0] d);
    logic signed [SW-1:0] s;
    s = $signed({2'b00, p >> 1}) + SW'(d);
    if (s < 0)                    return '0;
    if (s > $signed({2'b00, p}))  return {1'b0, p};
    return s[CW:0];
  endfunction

  logic [CW-1:0] cnt;
  logic          turn;
  logic [CW:0]   lvl;
  logic          mid_demand;

  assign lvl        = level_of(half_period, demand);
  assign mid_demand = (demand == '0);
  assign peak_stb   = turn;

  tri_carrier #(.CW(CW)) i_carrier (
    .clk(clk), .rst_n(rst_n), .half_period(half_period),
    .cnt(cnt), .turn(turn)
  );

  bridge_leg #(.CW(CW), .MIRROR(1'b0)) i_leg_a (
    .clk(clk), .rst_n(rst_n), .en(en), .cnt(cnt),
    .half_period(half_period), .lvl(lvl), .drv(drive_a)
  );

  bridge_leg #(.CW(CW), .MIRROR(1'b1)) i_leg_b (
    .clk(clk), .rst_n(rst_n), .en(en), .cnt(cnt),
    .half_period(half_period), .lvl(lvl), .drv(drive_b)
  );

  // R5: mid-scale demand with an even ramp keeps both legs in phase
  p_inphase_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (mid_demand && en && !half_period[0]) |=> (drive_a == drive_b));

  // R6: full positive level saturates A high and B low
  p_sat_pos_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (en && lvl == {1'b0, half_period} && cnt < half_period) |=> (drive_a && !drive_b));

  // R6: zero level saturates A low and B high
  p_sat_neg_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (en && lvl == '0 && cnt < half_period) |=> (!drive_a && drive_b));

  // R1: reset holds both drives low
  p_reset_low_r1: assert property (@(posedge clk)
    !rst_n |=> (!drive_a && !drive_b));
endmodule

// File: tb/test_phase_shift_pwm.sv
module test_phase_shift_pwm;
  localparam int CW = 8;

  logic               clk = 1'b0;
  logic               rst_n;
  logic               en;
  logic [CW-1:0]      half_period;
  logic signed [CW:0] demand;
  logic               drive_a, drive_b, peak_stb;

  int vectors = 0;
  int miscompares = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  phase_shift_pwm #(.CW(CW)) i_phase_shift_pwm (
    .clk(clk), .rst_n(rst_n), .en(en), .half_period(half_period),
    .demand(demand), .drive_a(drive_a), .drive_b(drive_b), .peak_stb(peak_stb)
  );

  // Window results
  int na, nb, ns, nrise, gap;
  bit all_eq;

  task automatic chk(input string req, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int exp_level(input int p, input int d);
    int l;
    l = p / 2 + d;
    if (l < 0) l = 0;
    if (l > p) l = p;
    return l;
  endfunction

  task automatic apply(input int p, input int d, input bit e);
    @(negedge clk);
    half_period = CW'(p);
    demand = (CW+1)'(d);
    en = e;
    repeat (40) @(negedge clk);
  endtask

  // Observe 2p+1 samples: counts over the first 2p, edges over 2p transitions.
  task automatic measure(input int p);
    bit prev_x, x;
    int first_s;
    na = 0; nb = 0; ns = 0; nrise = 0; gap = -1; all_eq = 1'b1;
    first_s = -1;
    prev_x = drive_a ^ drive_b;
    for (int i = 0; i < 2 * p; i++) begin
      @(negedge clk);
      if (drive_a) na++;
      if (drive_b) nb++;
      if (drive_a != drive_b) all_eq = 1'b0;
      if (peak_stb) begin
        ns++;
        if (first_s < 0) first_s = i;
        else if (gap < 0) gap = i - first_s;
      end
      x = drive_a ^ drive_b;
      if (x && !prev_x) nrise++;
      prev_x = x;
    end
  endtask

  task automatic t_reset;
    rst_n = 1'b0; en = 1'b1; half_period = CW'(16); demand = '0;
    repeat (3) @(negedge clk);
    chk("R1 drive_a in reset", int'(drive_a), 0);
    chk("R1 drive_b in reset", int'(drive_b), 0);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic t_carrier(input int p);
    apply(p, 0, 1'b1);
    measure(p);
    chk("R2 strobes per period", ns, 2);
    chk("R2 strobe spacing", gap, p);
  endtask

  task automatic t_duty(input int p, input int d);
    int l;
    l = exp_level(p, d);
    apply(p, d, 1'b1);
    measure(p);
    chk($sformatf("R3 A high count p=%0d d=%0d", p, d), na, 2 * l);
    chk($sformatf("R4 B high count p=%0d d=%0d", p, d), nb, 2 * (p - l));
  endtask

  task automatic t_inphase(input int p);
    apply(p, 0, 1'b1);
    measure(p);
    chk("R5 A equals B each cycle", int'(all_eq), 1);
    chk("R5 A high count", na, p);
    chk("R5 B high count", nb, p);
  endtask

  task automatic t_saturate(input int p, input int d, input bit a_on);
    apply(p, d, 1'b1);
    measure(p);
    chk($sformatf("R6 A count d=%0d", d), na, a_on ? 2 * p : 0);
    chk($sformatf("R6 B count d=%0d", d), nb, a_on ? 0 : 2 * p);
  endtask

  task automatic t_disable(input int p);
    apply(p, 3, 1'b1);
    @(negedge clk);
    en = 1'b0;
    @(negedge clk);
    chk("R7 drive_a one cycle after disable", int'(drive_a), 0);
    chk("R7 drive_b one cycle after disable", int'(drive_b), 0);
    measure(p);
    chk("R7 drive_a while disabled", na, 0);
    chk("R7 drive_b while disabled", nb, 0);
    chk("R7 strobes continue", ns, 2);
    @(negedge clk);
    en = 1'b1;
  endtask

  task automatic t_chop(input int p, input int d);
    apply(p, d, 1'b1);
    measure(p);
    chk($sformatf("R8 differential rises d=%0d", d), nrise, 2);
  endtask

  // Saturated demand: enable edge shows at the drives exactly one cycle later.
  task automatic t_latency(input int p);
    apply(p, p, 1'b0);
    @(negedge clk);
    en = 1'b1;
    chk("R9 drive_a before clock", int'(drive_a), 0);
    @(negedge clk);
    chk("R9 drive_a one clock after enable", int'(drive_a), 1);
    demand = (CW+1)'(-p);
    chk("R9 drive_b before clock", int'(drive_b), 0);
    @(negedge clk);
    chk("R9 drive_b one clock after demand swing", int'(drive_b), 1);
  endtask

  initial begin
    t_reset();
    t_carrier(16);
    t_carrier(10);
    t_inphase(16);
    t_duty(16, 3);
    t_duty(16, -5);
    t_duty(16, 7);
    t_duty(10, 2);
    t_saturate(16, 8, 1'b1);
    t_saturate(16, 40, 1'b1);
    t_saturate(16, -8, 1'b0);
    t_saturate(16, -100, 1'b0);
    t_disable(16);
    t_chop(16, 3);
    t_chop(16, -6);
    t_latency(16);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      vectors++;
      miscompares++;
      $display("FAIL watchdog (all requirements) actual=timeout expected=completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end
endmodule